// File: doc/BRIEF.md
# Virtual Interrupt Routing Unit

This unit decides, for a core with one hypervisor level, which pending interrupt is taken next, at which exception level, and whether it is delivered as physical or virtual. There are three interrupt kinds: normal, fast and system error. Each kind has a physical request line. It also has a virtual request, formed from a software-set bit and an external interrupt controller's virtual line. The unit combines these requests with the current exception level, a per-kind routing override and a host trap bit. The three processor-state mask bits then decide what may be taken.

Requests are captured into pending flags. The unit issues a one-cycle take strobe with the target level, the kind and a virtual flag. That strobe works as a valid with back-pressure: once it fires, no further take is issued until the core returns an acknowledge naming the same kind and type. Only a matching acknowledge clears the pending flag it names. A request whose conditions do not allow it to be taken stays pending and is not lost.

Top module: `vir_router`

## Requirements
- R1: Each physical and each virtual request sets its own pending flag on the clock edge where it is sampled high. The flag stays set until an acknowledge for that kind and type (ack_virt 0 for physical, 1 for virtual). If the request is still high in the same cycle as the acknowledge, the flag stays set.
- R2: take is high for exactly one cycle. When no take is outstanding, a request sampled at edge n produces take after edge n+1. After a take, no further take is issued until an acknowledge that matches its take_kind and take_virt.
- R3: When several candidates are takeable in the same cycle, the order is fixed: kind 2 (system error), then kind 1 (fast), then kind 0 (normal). Within one kind, physical is taken before virtual. Bit k of every per-kind vector, and the take_kind code k, refer to the same kind.
- R4: With the override for a kind clear, and host trap not in effect, a physical request at level 0 or 1 is taken at level 1 only while its mask bit is 0. A virtual request of that kind is never taken.
- R5: With the override for a kind set at level 0 or 1, a physical request is taken at level 2 whatever its mask bit. A virtual request is taken at level 1, with take_virt 1, only while the mask bit is 0.
- R6: At level 2, a physical request routed to level 2 is taken only while its mask bit is 0. Physical requests routed to level 1 stay pending, and so do all virtual requests.
- R7: At level 3, nothing is taken and all pending flags are kept.
- R8: The virtual request of a kind is the OR of its software bit and its external controller line. Either one alone leads to a virtual take.
- R9: At level 0 with host_trap 1, the overrides are ignored. Every physical request is taken at level 2 whatever its mask bit, and no virtual request is taken.
- R10: During and right after reset, take is 0 and all pending flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phys_req | input | 3 | Physical requests, bit per kind |
| virt_sw | input | 3 | Software-set virtual request bits |
| virt_ext | input | 3 | External controller virtual lines |
| cur_el | input | 2 | Current exception level 0..3 |
| route_ovr | input | 3 | Per-kind routing override |
| host_trap | input | 1 | Host trap enable, effective at level 0 |
| state_mask | input | 3 | Processor-state mask bits per kind |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_kind | input | 2 | Kind code being acknowledged |
| ack_virt | input | 1 | 1 acknowledges the virtual flag, 0 the physical one |
| take | output | 1 | One-cycle take strobe |
| take_el | output | 2 | Target level, valid with take |
| take_virt | output | 1 | Taken interrupt is virtual, valid with take |
| take_kind | output | 2 | Kind code taken, valid with take |

## Verification
Two things can fall in the same cycle and must be handled together. One is an acknowledge that clears a pending flag while its request is still driven high. The other is physical and virtual candidates of several kinds becoming takeable at the same edge, often just as the level leaves 2 or 3. Directed sequences build these cases on purpose: they pile up pending flags while the level blocks them, then release them together. A long constrained-random run then overlaps acknowledges with new requests and changes of level, override and mask. Every strobe is compared with a bench model of the routing and priority rules.

// File: rtl/vir_pkg.sv
package vir_pkg;
  localparam int unsigned KINDS = 3;
  localparam int unsigned KW    = $clog2(KINDS);
  localparam int unsigned LW    = 2;
  localparam logic [LW-1:0] LVL_GUEST = 2'd1;
  localparam logic [LW-1:0] LVL_HYP   = 2'd2;
  localparam logic [LW-1:0] LVL_TOP   = 2'd3;
endpackage

// File: rtl/vir_pend_bank.sv
module vir_pend_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= (pend_q[i] & ~clr_i[i]) | set_i[i];
    end

    assert_pend_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[i] && !clr_i[i]) |=> pend_q[i]);
    assert_pend_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> pend_q[i]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/vir_route_eval.sv
module vir_route_eval
  import vir_pkg::*;
(
  input  logic          ppend_i,
  input  logic          vpend_i,
  input  logic [LW-1:0] el_i,
  input  logic          ovr_i,
  input  logic          host_trap_i,
  input  logic          mask_i,
  output logic          p_ok_o,
  output logic [LW-1:0] p_lvl_o,
  output logic          v_ok_o
);
  logic at_low, at_hyp, trap_on, to_hyp;

  always_comb begin
    at_low  = (el_i < LVL_HYP);
    at_hyp  = (el_i == LVL_HYP);
    trap_on = host_trap_i && (el_i == '0);       // R9
    to_hyp  = ovr_i || trap_on;
    p_lvl_o = to_hyp ? LVL_HYP : LVL_GUEST;
    if (to_hyp) p_ok_o = ppend_i && (at_low || (at_hyp && !mask_i));  // R5 R6
    else        p_ok_o = ppend_i && at_low && !mask_i;                // R4
    v_ok_o = vpend_i && ovr_i && !trap_on && at_low && !mask_i;       // R5 R7
  end
endmodule

// File: rtl/vir_pick.sv
module vir_pick
  import vir_pkg::*;
#(
  parameter int unsigned N = KINDS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          p_ok_i,
  input  logic [N-1:0][LW-1:0]  p_lvl_i,
  input  logic [N-1:0]          v_ok_i,
  input  logic                  ack_valid_i,
  input  logic [KW-1:0]         ack_kind_i,
  input  logic                  ack_virt_i,
  output logic                  take_o,
  output logic [LW-1:0]         take_lvl_o,
  output logic                  take_virt_o,
  output logic [KW-1:0]         take_kind_o
);
  logic          sel_any, sel_v, ack_hit;
  logic [KW-1:0] sel_k;
  logic [LW-1:0] sel_l;
  logic          busy_q, take_q, virt_q;
  logic [KW-1:0] kind_q;
  logic [LW-1:0] lvl_q;

  // R3: ascending scan, later hits override: higher kind wins, physical beats virtual
  always_comb begin
    sel_any = 1'b0;
    sel_v   = 1'b0;
    sel_k   = '0;
    sel_l   = '0;
    for (int k = 0; k < int'(N); k++) begin
      if (v_ok_i[k]) begin
        sel_any = 1'b1; sel_v = 1'b1; sel_k = KW'(k); sel_l = LVL_GUEST;
      end
      if (p_ok_i[k]) begin
        sel_any = 1'b1; sel_v = 1'b0; sel_k = KW'(k); sel_l = p_lvl_i[k];
      end
    end
    ack_hit = ack_valid_i && busy_q && (ack_kind_i == kind_q) && (ack_virt_i == virt_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      take_q <= 1'b0;
      virt_q <= 1'b0;
      kind_q <= '0;
      lvl_q  <= '0;
    end else begin
      take_q <= !busy_q && sel_any;
      if (!busy_q && sel_any) begin
        busy_q <= 1'b1;
        virt_q <= sel_v;
        kind_q <= sel_k;
        lvl_q  <= sel_l;
      end else if (ack_hit) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign take_o      = take_q;
  assign take_lvl_o  = lvl_q;
  assign take_virt_o = virt_q;
  assign take_kind_o = kind_q;

  assert_take_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |=> !take_q);
  assert_wait_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ack_hit) |=> !take_q);
  assert_top_kind_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && p_ok_i[N-1]) |=> (take_q && !virt_q && kind_q == KW'(N-1)));
endmodule

// File: rtl/vir_router.sv
module vir_router
  import vir_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    phys_req,
  input  logic [2:0]    virt_sw,
  input  logic [2:0]    virt_ext,
  input  logic [1:0]    cur_el,
  input  logic [2:0]    route_ovr,
  input  logic          host_trap,
  input  logic [2:0]    state_mask,
  input  logic          ack_valid,
  input  logic [1:0]    ack_kind,
  input  logic          ack_virt,
  output logic          take,
  output logic [1:0]    take_el,
  output logic          take_virt,
  output logic [1:0]    take_kind
);
  logic [KINDS-1:0]         p_clr, v_clr, v_set, p_pend, v_pend, p_ok, v_ok;
  logic [KINDS-1:0][LW-1:0] p_lvl;

  for (genvar k = 0; k < KINDS; k++) begin : g_kind
    assign p_clr[k] = ack_valid && !ack_virt && (ack_kind == KW'(k));
    assign v_clr[k] = ack_valid &&  ack_virt && (ack_kind == KW'(k));
    assign v_set[k] = virt_sw[k] | virt_ext[k];   // R8

    vir_route_eval u_eval (
      .ppend_i     (p_pend[k]),
      .vpend_i     (v_pend[k]),
      .el_i        (cur_el),
      .ovr_i       (route_ovr[k]),
      .host_trap_i (host_trap),
      .mask_i      (state_mask[k]),
      .p_ok_o      (p_ok[k]),
      .p_lvl_o     (p_lvl[k]),
      .v_ok_o      (v_ok[k])
    );
  end

  vir_pend_bank #(.N(KINDS)) u_ppend (
    .clk(clk), .rst_n(rst_n), .set_i(phys_req), .clr_i(p_clr), .pend_o(p_pend));

  vir_pend_bank #(.N(KINDS)) u_vpend (
    .clk(clk), .rst_n(rst_n), .set_i(v_set), .clr_i(v_clr), .pend_o(v_pend));

  vir_pick #(.N(KINDS)) u_pick (
    .clk         (clk),
    .rst_n       (rst_n),
    .p_ok_i      (p_ok),
    .p_lvl_i     (p_lvl),
    .v_ok_i      (v_ok),
    .ack_valid_i (ack_valid),
    .ack_kind_i  (ack_kind),
    .ack_virt_i  (ack_virt),
    .take_o      (take),
    .take_lvl_o  (take_el),
    .take_virt_o (take_virt),
    .take_kind_o (take_kind)
  );

  assert_virt_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_virt) |-> ($past(cur_el) < LVL_HYP));
  assert_virt_guest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_virt) |-> (take_el == LVL_GUEST));
  assert_top_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cur_el) == LVL_TOP) |-> !take);
  assert_target_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (take_el != 2'd0 && take_el != LVL_TOP));
endmodule

// File: tb/tb_vir_router.sv
module tb_vir_router;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] phys_req = '0, virt_sw = '0, virt_ext = '0, route_ovr = '0, state_mask = '0;
  logic [1:0] cur_el = 2'd1, ack_kind = '0;
  logic       host_trap = 1'b0, ack_valid = 1'b0, ack_virt = 1'b0;
  logic       take, take_virt;
  logic [1:0] take_el, take_kind;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  vir_router dut (
    .clk(clk), .rst_n(rst_n), .phys_req(phys_req), .virt_sw(virt_sw), .virt_ext(virt_ext),
    .cur_el(cur_el), .route_ovr(route_ovr), .host_trap(host_trap), .state_mask(state_mask),
    .ack_valid(ack_valid), .ack_kind(ack_kind), .ack_virt(ack_virt),
    .take(take), .take_el(take_el), .take_virt(take_virt), .take_kind(take_kind));

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // ---------------- reference model from the requirements ----------------
  bit [2:0] m_pp, m_vp;
  bit       m_busy, m_take, m_virt, m_found, m_fv;
  int       m_kind, m_el, m_fk, m_fl;

  function automatic bit trap_now();
    return host_trap && cur_el == 2'd0;
  endfunction
  function automatic bit phys_ok(int k);
    bit hyp = route_ovr[k] || trap_now();
    if (!m_pp[k] || cur_el == 2'd3) return 0;
    if (hyp) return (cur_el <= 2'd1) || (cur_el == 2'd2 && !state_mask[k]);
    return (cur_el <= 2'd1) && !state_mask[k];
  endfunction
  function automatic bit virt_ok(int k);
    return m_vp[k] && route_ovr[k] && !trap_now() && cur_el <= 2'd1 && !state_mask[k];
  endfunction
  function automatic int phys_lvl(int k);
    return (route_ovr[k] || trap_now()) ? 2 : 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pp = '0; m_vp = '0; m_busy = 0; m_take = 0;
    end else begin
      m_found = 0; m_fk = 0; m_fv = 0; m_fl = 0;
      if (!m_busy)
        for (int k = 0; k < 3; k++) begin
          if (virt_ok(k)) begin m_found = 1; m_fk = k; m_fv = 1; m_fl = 1; end
          if (phys_ok(k)) begin m_found = 1; m_fk = k; m_fv = 0; m_fl = phys_lvl(k); end
        end
      m_take = m_found;
      if (m_found) begin
        m_busy = 1; m_kind = m_fk; m_virt = m_fv; m_el = m_fl;
      end else if (m_busy && ack_valid && int'(ack_kind) == m_kind && ack_virt == m_virt)
        m_busy = 0;
      for (int k = 0; k < 3; k++) begin
        if (ack_valid && int'(ack_kind) == k) begin
          if (ack_virt) m_vp[k] = 0; else m_pp[k] = 0;
        end
        if (phys_req[k]) m_pp[k] = 1;
        if (virt_sw[k] || virt_ext[k]) m_vp[k] = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(take == m_take, "R2 R3 model take", take, m_take);
      if (m_take && take) begin
        chk(int'(take_kind) == m_kind, "R3 model kind", take_kind, m_kind);
        chk(int'(take_el) == m_el, "R4 R5 R9 model level", take_el, m_el);
        chk(take_virt == m_virt, "R5 model virt", take_virt, m_virt);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic pulse(logic [2:0] p, logic [2:0] s, logic [2:0] e);
    phys_req = p; virt_sw = s; virt_ext = e;
    @(negedge clk);
    phys_req = '0; virt_sw = '0; virt_ext = '0;
  endtask

  task automatic expect_take(int k, int lvl, bit v, string tag);
    bit seen = 0;
    for (int i = 0; i < 8 && !seen; i++) begin
      @(negedge clk);
      if (take) seen = 1;
    end
    chk(seen, tag, take, 1);
    if (seen) begin
      chk(int'(take_kind) == k, tag, take_kind, k);
      chk(int'(take_el) == lvl, tag, take_el, lvl);
      chk(take_virt == v, tag, take_virt, v);
    end
  endtask

  task automatic expect_none(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(take == 1'b0, tag, take, 0);
    end
  endtask

  task automatic do_ack(int k, bit v);
    ack_valid = 1; ack_kind = 2'(k); ack_virt = v;
    @(negedge clk);
    ack_valid = 0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(take == 1'b0, "R10 take in reset", take, 0);
    rst_n = 1;
    expect_none(2, "R10 idle after reset");

    // R4 plain routing to level 1
    pulse(3'b001, 0, 0);
    expect_take(0, 1, 0, "R4 phys to level 1");
    expect_none(3, "R2 no retake before ack");
    do_ack(0, 0);
    expect_none(3, "R1 cleared by ack");
    state_mask = 3'b010;
    pulse(3'b010, 0, 0);
    expect_none(4, "R4 masked physical");
    state_mask = 3'b000;
    expect_take(1, 1, 0, "R4 R1 held then taken");
    do_ack(1, 0);
    pulse(0, 3'b001, 0);
    expect_none(4, "R4 virtual not taken without override");
    do_ack(0, 1);

    // R5 override set
    route_ovr = 3'b001; state_mask = 3'b001;
    pulse(3'b001, 0, 0);
    expect_take(0, 2, 0, "R5 phys to level 2 despite mask");
    do_ack(0, 0);
    pulse(0, 3'b001, 0);
    expect_none(4, "R5 virtual masked");
    state_mask = 3'b000;
    expect_take(0, 1, 1, "R5 virtual taken");
    do_ack(0, 1);

    // R8 external line
    route_ovr = 3'b010;
    pulse(0, 0, 3'b010);
    expect_take(1, 1, 1, "R8 external virtual line");
    do_ack(1, 1);

    // R6 level 2
    cur_el = 2'd2; route_ovr = 3'b110; state_mask = 3'b100;
    pulse(3'b100, 0, 0);
    expect_none(4, "R6 masked at level 2");
    state_mask = 3'b000;
    expect_take(2, 2, 0, "R6 unmasked at level 2");
    do_ack(2, 0);
    pulse(3'b001, 3'b010, 0);
    expect_none(4, "R6 level-1 phys and virtual held");
    cur_el = 2'd1;
    expect_take(1, 1, 1, "R6 R3 virtual fast released");
    do_ack(1, 1);
    expect_take(0, 1, 0, "R6 normal released");
    do_ack(0, 0);

    // R7 level 3
    cur_el = 2'd3; route_ovr = 3'b111;
    pulse(3'b001, 3'b100, 0);
    expect_none(5, "R7 nothing at level 3");
    cur_el = 2'd1;
    expect_take(2, 1, 1, "R7 R3 held virtual taken");
    do_ack(2, 1);
    expect_take(0, 2, 0, "R7 held physical taken");
    do_ack(0, 0);

    // R3 priority
    route_ovr = 3'b000;
    pulse(3'b111, 0, 0);
    expect_take(2, 1, 0, "R3 system error first");
    do_ack(2, 0);
    expect_take(1, 1, 0, "R3 fast second");
    do_ack(1, 0);
    expect_take(0, 1, 0, "R3 normal last");
    do_ack(0, 0);
    route_ovr = 3'b010;
    pulse(3'b010, 3'b010, 0);
    expect_take(1, 2, 0, "R3 physical before virtual");
    do_ack(1, 0);
    expect_take(1, 1, 1, "R3 virtual after physical");
    do_ack(1, 1);

    // R9 host trap at level 0
    cur_el = 2'd0; host_trap = 1; route_ovr = 3'b000; state_mask = 3'b001;
    pulse(3'b001, 0, 0);
    expect_take(0, 2, 0, "R9 trap routes to level 2");
    do_ack(0, 0);
    route_ovr = 3'b010;
    pulse(0, 3'b010, 0);
    expect_none(4, "R9 virtual blocked by trap");
    do_ack(1, 1);
    expect_none(2, "R1 virtual cleared by ack");
    host_trap = 0; route_ovr = 0; state_mask = 0; cur_el = 2'd1;

    // constrained random
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        phys_req[k] = ($urandom % 8) == 0;
        virt_sw[k]  = ($urandom % 16) == 0;
        virt_ext[k] = ($urandom % 16) == 0;
        if (($urandom % 32) == 0) route_ovr[k] = ~route_ovr[k];
        if (($urandom % 24) == 0) state_mask[k] = ~state_mask[k];
      end
      if (($urandom % 32) == 0) cur_el = 2'($urandom % 4);
      if (($urandom % 40) == 0) host_trap = ~host_trap;
      if (m_busy && ($urandom % 3) == 0) begin
        ack_valid = 1; ack_kind = 2'(m_kind); ack_virt = m_virt;
      end else if (($urandom % 20) == 0) begin
        ack_valid = 1; ack_kind = 2'($urandom % 3); ack_virt = 1'($urandom % 2);
      end else
        ack_valid = 0;
    end
    @(negedge clk);
    phys_req = 0; virt_sw = 0; virt_ext = 0; ack_valid = 0;
    @(negedge clk);
    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end
endmodule